// File: doc/BRIEF.md
# Servo Tracking Mode Controller

This block chooses how aggressively a sample-rate tracking servo loop runs. It holds the loop in a fast, high-gain tracking mode after reset and after every detected rate change. It drops to a slow, low-gain mode once the tracking error has stayed small for a run of output periods. A mute request follows the fast interval, so downstream audio can be silenced while the loop is still acquiring lock. The servo filter arithmetic is out of scope.

The signed error is looked at only in cycles where the one-cycle output-period strobe is high. A settle counter counts consecutive strobed samples whose magnitude is strictly below a programmable threshold. When the count reaches `SETTLE_N`, the mode switches to slow. A rate-change strobe restarts acquisition on the next clock from either mode.

Top module: `servo_mode_ctrl`

## Requirements
- R1: After reset is released, fast_o and mute_o are 1 and gain_sel_o equals FAST_GAIN (default 12).
- R2: A rate_chg_i pulse seen in slow mode makes fast_o 1 on the next clock.
- R3: Fast mode becomes slow on the clock after the SETTLE_N-th (default 16) consecutive strobed sample with |err_i| < thresh_i. SETTLE_N-1 such samples leave the block in fast mode.
- R4: A strobed sample with |err_i| >= thresh_i clears the run. A magnitude equal to the threshold counts as outside.
- R5: mute_o equals fast_o in every cycle.
- R6: gain_sel_o is FAST_GAIN (12) in fast mode and SLOW_GAIN (default 4) in slow mode.
- R7: err_i has no effect in cycles where period_stb_i is 0.
- R8: A rate_chg_i pulse in fast mode clears the settle run, so SETTLE_N fresh in-band samples are needed after it.
- R9: When rate_chg_i and period_stb_i are high together, the rate change wins and the block is in fast mode next cycle.
- R10: In slow mode, strobed samples of any magnitude leave the block in slow mode.
- R11: err_i is two's complement. Its magnitude is taken exactly, so the most negative value has magnitude 2^(ERR_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rate_chg_i | input | 1 | One-cycle strobe: sample-rate change detected |
| period_stb_i | input | 1 | One-cycle strobe per output-sample period |
| err_i | input | ERR_W | Signed tracking error |
| thresh_i | input | ERR_W | Unsigned settling threshold |
| fast_o | output | 1 | 1 in fast mode, 0 in slow mode |
| gain_sel_o | output | GAIN_W | Loop gain shift code for the servo filter |
| mute_o | output | 1 | Mute request, high during fast mode |

## Verification
The assertions assume that thresh_i is stable across a settle run. They also assume that err_i and thresh_i are only meaningful when period_stb_i is high. The stimulus changes thresh_i only just after a rate change has restarted acquisition. Between strobes it drives large off-band errors, so any sampling outside strobe cycles would show up as a broken run. Rate changes are driven both alone and together with strobes, in both modes.

// File: rtl/servo_mode_pkg.sv
package servo_mode_pkg;
  typedef enum logic {
    MODE_FAST = 1'b0,
    MODE_SLOW = 1'b1
  } servo_mode_e;
endpackage

// File: rtl/servo_err_judge.sv
module servo_err_judge #(
  parameter int ERR_W = 16
) (
  input  logic signed [ERR_W-1:0] err_i,
  input  logic        [ERR_W-1:0] thresh_i,
  output logic                    in_band_o
);
  // one extra bit so the most negative value keeps its exact magnitude
  localparam int MAG_W = ERR_W + 1;
  logic [MAG_W-1:0] ext, mag;

  always_comb begin
    ext = {err_i[ERR_W-1], err_i};
    mag = err_i[ERR_W-1] ? (~ext + MAG_W'(1)) : ext;
    in_band_o = mag < {1'b0, thresh_i};
  end
endmodule

// File: rtl/servo_settle_cnt.sv
module servo_settle_cnt #(
  parameter int SETTLE_N = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic stb_i,
  input  logic in_band_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(SETTLE_N + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_N - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit    = !clr_i && stb_i && in_band_i;
  assign done_o = hit && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (stb_i && !in_band_i) cnt_q <= '0;
    else if (done_o)             cnt_q <= '0;
    else if (hit)                cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/servo_mode_reg.sv
module servo_mode_reg
  import servo_mode_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rate_chg_i,
  input  logic        settled_i,
  output servo_mode_e mode_o
);
  servo_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_FAST;
    else if (rate_chg_i) mode_q <= MODE_FAST;
    else if (settled_i)  mode_q <= MODE_SLOW;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/servo_mode_ctrl.sv
module servo_mode_ctrl
  import servo_mode_pkg::*;
#(
  parameter int ERR_W     = 16,
  parameter int SETTLE_N  = 16,
  parameter int GAIN_W    = 4,
  parameter int FAST_GAIN = 12,
  parameter int SLOW_GAIN = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rate_chg_i,
  input  logic                    period_stb_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic        [ERR_W-1:0] thresh_i,
  output logic                    fast_o,
  output logic       [GAIN_W-1:0] gain_sel_o,
  output logic                    mute_o
);
  localparam logic [GAIN_W-1:0] GAIN_HI = GAIN_W'(FAST_GAIN);
  localparam logic [GAIN_W-1:0] GAIN_LO = GAIN_W'(SLOW_GAIN);

  logic        in_band, settled, cnt_clr;
  servo_mode_e mode;

  servo_err_judge #(.ERR_W(ERR_W)) i_judge (
    .err_i    (err_i),
    .thresh_i (thresh_i),
    .in_band_o(in_band)
  );

  // counting only runs in fast mode; a rate change restarts it
  assign cnt_clr = rate_chg_i || (mode == MODE_SLOW);

  servo_settle_cnt #(.SETTLE_N(SETTLE_N)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cnt_clr),
    .stb_i    (period_stb_i),
    .in_band_i(in_band),
    .done_o   (settled)
  );

  servo_mode_reg i_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rate_chg_i(rate_chg_i),
    .settled_i (settled),
    .mode_o    (mode)
  );

  assign fast_o     = (mode == MODE_FAST);
  assign mute_o     = fast_o;
  assign gain_sel_o = fast_o ? GAIN_HI : GAIN_LO;
endmodule

// File: rtl/servo_mode_chk.sv
module servo_mode_chk #(
  parameter int ERR_W     = 16,
  parameter int SETTLE_N  = 16,
  parameter int GAIN_W    = 4,
  parameter int FAST_GAIN = 12,
  parameter int SLOW_GAIN = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    rate_chg_i,
  input logic                    period_stb_i,
  input logic signed [ERR_W-1:0] err_i,
  input logic        [ERR_W-1:0] thresh_i,
  input logic                    fast_o,
  input logic       [GAIN_W-1:0] gain_sel_o,
  input logic                    mute_o
);
  localparam int RUN_W = $clog2(SETTLE_N + 1);

  logic [RUN_W-1:0] run_q;
  longint           mag;
  logic             good;

  always_comb begin
    mag  = longint'(err_i);
    if (mag < 0) mag = -mag;
    good = mag < longint'(thresh_i);
  end

  // independent run length of in-band strobes seen while fast
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     run_q <= '0;
    else if (rate_chg_i || !fast_o)  run_q <= '0;
    else if (period_stb_i)
      run_q <= !good ? '0 : (run_q == RUN_W'(SETTLE_N)) ? run_q : run_q + RUN_W'(1);
  end

  assert_mute_tracks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o == fast_o);

  assert_gain_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_sel_o == (fast_o ? GAIN_W'(FAST_GAIN) : GAIN_W'(SLOW_GAIN)));

  assert_rate_to_fast_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_chg_i |=> fast_o);

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!period_stb_i && !rate_chg_i) |=> $stable(fast_o));

  assert_slow_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_o && !rate_chg_i) |=> !fast_o);

  assert_full_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fast_o) |-> (run_q == RUN_W'(SETTLE_N)));

  assert_bad_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_o && period_stb_i && !good) |=> fast_o);
endmodule

bind servo_mode_ctrl servo_mode_chk #(
  .ERR_W(ERR_W), .SETTLE_N(SETTLE_N), .GAIN_W(GAIN_W),
  .FAST_GAIN(FAST_GAIN), .SLOW_GAIN(SLOW_GAIN)
) i_servo_mode_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rate_chg_i(rate_chg_i),
  .period_stb_i(period_stb_i), .err_i(err_i), .thresh_i(thresh_i),
  .fast_o(fast_o), .gain_sel_o(gain_sel_o), .mute_o(mute_o)
);

// File: tb/test_servo_mode_ctrl.sv
module test_servo_mode_ctrl;
  localparam int ERR_W = 16;
  localparam int N     = 16;
  localparam int G_HI  = 12;
  localparam int G_LO  = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rate_chg_i = 1'b0;
  logic period_stb_i = 1'b0;
  logic signed [ERR_W-1:0] err_i = '0;
  logic [ERR_W-1:0] thresh_i = 16'd100;
  logic fast_o, mute_o;
  logic [3:0] gain_sel_o;

  int n_checks = 0;
  int n_fail = 0;
  int m_fast, m_cnt;

  always #5 clk_i = ~clk_i;

  servo_mode_ctrl i_servo_mode_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_chg_i(rate_chg_i),
    .period_stb_i(period_stb_i), .err_i(err_i), .thresh_i(thresh_i),
    .fast_o(fast_o), .gain_sel_o(gain_sel_o), .mute_o(mute_o)
  );

  // behavioural reference
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_fast = 1; m_cnt = 0;
    end else if (rate_chg_i) begin
      m_fast = 1; m_cnt = 0;
    end else if (m_fast == 1 && period_stb_i) begin
      automatic int e = int'(err_i);
      if (e < 0) e = -e;
      if (e < int'(thresh_i)) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == N) begin m_fast = 0; m_cnt = 0; end
      end else m_cnt = 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) if (rst_ni) begin
    chk("R3 fast_o vs model", int'(fast_o), m_fast);
    chk("R5 mute_o vs model", int'(mute_o), m_fast);
    chk("R6 gain_sel_o vs model", int'(gain_sel_o), m_fast ? G_HI : G_LO);
  end

  task automatic step(bit rc, bit stb, int e);
    rate_chg_i = rc; period_stb_i = stb; err_i = ERR_W'(e);
    @(posedge clk_i); @(negedge clk_i);
    rate_chg_i = 0; period_stb_i = 0; err_i = 16'sd9000;
  endtask

  task automatic good_runs(int k);
    for (int i = 0; i < k; i++) begin
      step(0, 1, (i % 2) ? -50 : 50);
      step(0, 0, -20000);  // off-band value between strobes
    end
  endtask

  initial begin
    #1ms;
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 fast after reset", int'(fast_o), 1);
    chk("R1 mute after reset", int'(mute_o), 1);
    chk("R1 gain after reset", int'(gain_sel_o), G_HI);

    good_runs(N - 1);
    chk("R3 N-1 samples stay fast", int'(fast_o), 1);
    chk("R7 off-strobe error ignored", int'(fast_o), 1);
    good_runs(1);
    chk("R3 N samples go slow", int'(fast_o), 0);
    chk("R6 slow gain", int'(gain_sel_o), G_LO);
    chk("R5 mute low in slow", int'(mute_o), 0);

    step(0, 1, 30000);
    step(0, 1, -30000);
    chk("R10 slow ignores large error", int'(fast_o), 0);

    step(1, 0, 0);
    chk("R2 rate change to fast", int'(fast_o), 1);
    chk("R6 fast gain", int'(gain_sel_o), G_HI);

    good_runs(10);
    step(0, 1, 100);  // equal to threshold: outside
    good_runs(N - 1);
    chk("R4 equal magnitude clears run", int'(fast_o), 1);
    good_runs(1);
    chk("R4 fresh run completes", int'(fast_o), 0);

    step(1, 0, 0);
    good_runs(10);
    step(1, 0, 0);
    good_runs(N - 1);
    chk("R8 rate change clears run", int'(fast_o), 1);
    good_runs(1);
    chk("R8 full run after restart", int'(fast_o), 0);

    step(1, 1, 0);
    chk("R9 rate wins over strobe", int'(fast_o), 1);

    thresh_i = 16'd32768;
    good_runs(N - 1);
    step(0, 1, -32768);  // magnitude 32768 not below 32768
    chk("R11 most negative out of band", int'(fast_o), 1);
    step(1, 0, 0);
    thresh_i = 16'd32769;
    for (int i = 0; i < N; i++) step(0, 1, -32768);
    chk("R11 most negative in band", int'(fast_o), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule